// File: doc/BRIEF.md
# Transmit Data Link FIFO with Interrupt Status

This block buffers outgoing data-link bytes for a framer. A host processor pushes bytes into a 128-entry, byte-wide queue; a serial transmit engine pulls them out in the same order. Next to the queue sits an eight-bit status word. It mixes live levels (full, near-empty) with latched events (underrun, message sent). The empty bit is kept as its own register.

The host reads the status word through a single read strobe. A read clears the latched event bits. The near-empty, underrun and message-sent conditions each have an enable input. Any enabled condition that is present raises one summary interrupt line toward global control in the same cycle. Full and empty never raise the interrupt. The engine signals the end of each message's closing flag with a one-cycle pulse.

Top module: `dl_tx_fifo_status`

## Requirements
- R1: After reset the status word reads 0x03 (empty at bit 0 and near-empty at bit 1 high, all others low), and with all enables low the interrupt is low.
- R2: Bytes leave the queue in the order they were written. The head byte is visible on the read-data output while the queue is not empty, and a pull advances it.
- R3: Bit 4 (full) is high exactly while the queue holds 128 bytes. It drops in the cycle after one byte is pulled from a full queue.
- R4: A write while the queue is full is discarded. After such a write, draining the queue yields only the 128 earlier bytes.
- R5: Bit 1 (near-empty) is high while the occupancy is less than or equal to the threshold input and low while the occupancy is above it.
- R6: Bit 0 (empty) rises after the last byte is pulled and falls after the first write that follows.
- R7: A pull while the queue is empty sets bit 2 (underrun). The bit stays set until a status read.
- R8: A pulse on the message-done input sets bit 3 (message sent). The bit stays set until a status read.
- R9: A status read clears bits 2 and 3 in the following cycle. An event arriving in the same cycle as the read leaves its bit set.
- R10: The interrupt output is high exactly when at least one of bits 1, 2 or 3 is high with its own enable high. Bits 0 and 4 never drive it.
- R11: Bits 7 to 5 of the status word always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| rd_en_i | input | 1 | Transmit engine pull strobe |
| rd_data_o | output | 8 | Head byte of the queue |
| near_thr_i | input | 7 | Near-empty threshold in bytes |
| msg_done_i | input | 1 | Closing flag of a message fully sent |
| stat_rd_i | input | 1 | Status read strobe, clears latched events |
| ie_near_i | input | 1 | Interrupt enable for near-empty |
| ie_undr_i | input | 1 | Interrupt enable for underrun |
| ie_msg_i | input | 1 | Interrupt enable for message sent |
| stat_o | output | 8 | Status word |
| irq_o | output | 1 | Summary interrupt |

## Verification
A status read can fall in the same cycle as a new message-done pulse. In that case the clear must lose to the event. The bench first latches the message bit, then drives the read strobe and a fresh message-done pulse on the same edge, and requires bit 3 to still be high afterwards. A second read with no event must then clear it. A host write and an engine pull can also coincide on an empty queue: the pull counts as an underrun while the write is accepted.

// File: rtl/dltx_pkg.sv
package dltx_pkg;
  localparam int unsigned ST_W     = 8;
  localparam int unsigned ST_EMPTY = 0;
  localparam int unsigned ST_NEAR  = 1;
  localparam int unsigned ST_UNDR  = 2;
  localparam int unsigned ST_MSG   = 3;
  localparam int unsigned ST_FULL  = 4;
  localparam logic [ST_W-1:0] ST_RST = 8'h03;
endpackage

// File: rtl/dltx_fifo.sv
module dltx_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          push_ok_o,
  output logic          pop_ok_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          full, emp;

  assign full      = (count_o == CW'(DEPTH));
  assign emp       = (count_o == '0);
  assign push_ok_o = push_i & ~full;
  assign pop_ok_o  = pop_i & ~emp;
  assign data_o    = mem[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_o <= '0;
    end else begin
      if (push_ok_o) wp_q <= nxt(wp_q);
      if (pop_ok_o)  rp_q <= nxt(rp_q);
      count_o <= count_o + CW'(push_ok_o) - CW'(pop_ok_o);
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  p_full_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i) |=> count_o == CW'(DEPTH));
  p_pop_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!emp && pop_i && !push_i) |=> count_o == $past(count_o) - 1'b1);
endmodule

// File: rtl/dltx_status.sv
module dltx_status
  import dltx_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CW-1:0]   count_i,
  input  logic            push_ok_i,
  input  logic            pop_ok_i,
  input  logic            pull_i,
  input  logic [AW-1:0]   thr_i,
  input  logic            msg_done_i,
  input  logic            stat_rd_i,
  input  logic            ie_near_i,
  input  logic            ie_undr_i,
  input  logic            ie_msg_i,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);
  logic empty_q, undr_q, msg_q;
  logic near, full, undr_evt;

  assign near     = (count_i <= CW'(thr_i));
  assign full     = (count_i == CW'(DEPTH));
  assign undr_evt = pull_i & empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      undr_q  <= 1'b0;
      msg_q   <= 1'b0;
    end else begin
      if (push_ok_i)                              empty_q <= 1'b0;
      else if (pop_ok_i && count_i == CW'(1))     empty_q <= 1'b1;
      // event beats a clearing read in the same cycle
      undr_q <= undr_evt   | (undr_q & ~stat_rd_i);
      msg_q  <= msg_done_i | (msg_q  & ~stat_rd_i);
    end
  end

  always_comb begin
    stat_o           = '0;
    stat_o[ST_EMPTY] = empty_q;
    stat_o[ST_NEAR]  = near;
    stat_o[ST_UNDR]  = undr_q;
    stat_o[ST_MSG]   = msg_q;
    stat_o[ST_FULL]  = full;
  end

  assign irq_o = (near & ie_near_i) | (undr_q & ie_undr_i) | (msg_q & ie_msg_i);

  p_empty_track_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_q == (count_i == '0));
  p_undr_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undr_evt |=> stat_o[ST_UNDR]);
  p_undr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[ST_UNDR] && !stat_rd_i) |=> stat_o[ST_UNDR]);
  p_msg_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_done_i |=> stat_o[ST_MSG]);
  p_msg_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !msg_done_i) |=> !stat_o[ST_MSG]);
  p_irq_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_near_i && !ie_undr_i && !ie_msg_i) |-> !irq_o);
endmodule

// File: rtl/dl_tx_fifo_status.sv
module dl_tx_fifo_status
  import dltx_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            rd_en_i,
  output logic [DW-1:0]   rd_data_o,
  input  logic [AW-1:0]   near_thr_i,
  input  logic            msg_done_i,
  input  logic            stat_rd_i,
  input  logic            ie_near_i,
  input  logic            ie_undr_i,
  input  logic            ie_msg_i,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  dltx_fifo #(.DEPTH(DEPTH), .DW(DW)) i_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (wr_en_i),
    .data_i   (wr_data_i),
    .pop_i    (rd_en_i),
    .data_o   (rd_data_o),
    .count_o  (count),
    .push_ok_o(push_ok),
    .pop_ok_o (pop_ok)
  );

  dltx_status #(.DEPTH(DEPTH)) i_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (count),
    .push_ok_i (push_ok),
    .pop_ok_i  (pop_ok),
    .pull_i    (rd_en_i),
    .thr_i     (near_thr_i),
    .msg_done_i(msg_done_i),
    .stat_rd_i (stat_rd_i),
    .ie_near_i (ie_near_i),
    .ie_undr_i (ie_undr_i),
    .ie_msg_i  (ie_msg_i),
    .stat_o    (stat_o),
    .irq_o     (irq_o)
  );

  p_rsv_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[7:5] == 3'b000);
endmodule

// File: tb/test_dl_tx_fifo_status.sv
module test_dl_tx_fifo_status;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, msg_done = 1'b0, stat_rd = 1'b0;
  logic       ie_near = 1'b0, ie_undr = 1'b0, ie_msg = 1'b0;
  logic [7:0] wr_data = '0;
  logic [6:0] thr = '0;
  logic [7:0] rd_data, stat;
  logic       irq;
  int         nvec = 0, nerr = 0;

  always #2 clk = ~clk;

  dl_tx_fifo_status i_dl_tx_fifo_status (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .near_thr_i(thr),
    .msg_done_i(msg_done), .stat_rd_i(stat_rd), .ie_near_i(ie_near),
    .ie_undr_i(ie_undr), .ie_msg_i(ie_msg), .stat_o(stat), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b; step(); wr_en = 1'b0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string req);
    chk(req, rd_data, exp);
    rd_en = 1'b1; step(); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 stat", stat, 8'h03);
    chk("R1 irq", irq, 1'b0);
    chk("R11 rsv", stat[7:5], 3'b000);
  endtask

  task automatic t_order();
    thr = 7'd2;
    push(8'h10); push(8'h20); push(8'h30); push(8'h40); push(8'h50);
    chk("R5 above", stat[1], 1'b0);
    chk("R6 not empty", stat[0], 1'b0);
    pop_chk(8'h10, "R2 d0"); pop_chk(8'h20, "R2 d1");
    chk("R5 occ3", stat[1], 1'b0);
    pop_chk(8'h30, "R2 d2");
    chk("R5 occ2", stat[1], 1'b1);
    pop_chk(8'h40, "R2 d3");
    chk("R6 one left", stat[0], 1'b0);
    pop_chk(8'h50, "R2 d4");
    chk("R6 drained", stat[0], 1'b1);
    push(8'h77);
    chk("R6 first write", stat[0], 1'b0);
    pop_chk(8'h77, "R2 d5");
    chk("R6 drained again", stat[0], 1'b1);
  endtask

  task automatic t_full();
    thr = 7'd0;
    for (int i = 0; i < 128; i++) begin
      if (i == 127) chk("R3 127 held", stat[4], 1'b0);
      push(8'(i * 3 + 1));
    end
    chk("R3 full", stat[4], 1'b1);
    chk("R10 full no irq", irq, 1'b0);
    push(8'hEE);
    chk("R4 still full", stat[4], 1'b1);
    pop_chk(8'(1), "R2 first");
    chk("R3 drop", stat[4], 1'b0);
    for (int i = 1; i < 128; i++) pop_chk(8'(i * 3 + 1), "R4 drain");
    chk("R4 empty after 128", stat[0], 1'b1);
    chk("R10 empty no irq", irq, 1'b0);
  endtask

  task automatic t_underrun();
    rd_en = 1'b1; step(); rd_en = 1'b0;
    chk("R7 set", stat[2], 1'b1);
    chk("R10 masked undr", irq, 1'b0);
    ie_undr = 1'b1; #1;
    chk("R10 undr irq", irq, 1'b1);
    step(); step();
    chk("R7 held", stat[2], 1'b1);
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
    chk("R9 undr clr", stat[2], 1'b0);
    chk("R10 irq drop", irq, 1'b0);
    ie_undr = 1'b0;
  endtask

  task automatic t_msg();
    msg_done = 1'b1; step(); msg_done = 1'b0;
    chk("R8 set", stat[3], 1'b1);
    chk("R10 masked msg", irq, 1'b0);
    ie_msg = 1'b1; #1;
    chk("R10 msg irq", irq, 1'b1);
    step();
    chk("R8 held", stat[3], 1'b1);
    stat_rd = 1'b1; msg_done = 1'b1; step(); stat_rd = 1'b0; msg_done = 1'b0;
    chk("R9 event wins", stat[3], 1'b1);
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
    chk("R9 msg clr", stat[3], 1'b0);
    ie_msg = 1'b0;
  endtask

  task automatic t_near_irq();
    thr = 7'd0; ie_near = 1'b1; #1;
    chk("R10 near irq", irq, 1'b1);
    push(8'hA5);
    chk("R5 occ1 thr0", stat[1], 1'b0);
    chk("R10 near gone", irq, 1'b0);
    wr_en = 1'b1; wr_data = 8'h3C; rd_en = 1'b1; step(); wr_en = 1'b0; rd_en = 1'b0;
    pop_chk(8'h3C, "R2 simul");
    chk("R6 end", stat, 8'h03);
    ie_near = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    step();
    t_reset();
    t_order();
    t_full();
    t_underrun();
    t_msg();
    t_near_irq();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule